// File: doc/BRIEF.md
# T1 Robbed-Bit Signaling Extractor

This block sits behind a T1 framer that has already aligned the received stream into channel bytes. Each byte arrives with its position in the multiframe (frame number and channel number). In the frames that carry robbed-bit signaling, the block takes the least significant bit of every channel byte and builds a per-channel codeword over the multiframe. It supports three multiframe formats (12, 24 and 72 frames), each with a 4-state or a 16-state selection. A fourth format carries no signaling and turns extraction off.

Completed codewords can pass through a two-in-a-row debounce and can be frozen. A freeze comes from a software bit, or from sync-loss and slip indications supplied by the framer and the elastic buffer. Surviving codewords land in a 24-entry store. Each channel that changes raises a change-of-state flag; the flags are read in groups of eight, reading clears them, and a masked interrupt is raised while any flag is set. The store and the per-channel enable bits are reached through a small indirect access port. Every incoming byte is passed on one cycle later, with the channel's stored codeword alongside it in the low nibble of a signaling byte.

Top module: `rbs_extractor`

## Requirements
- R1: A byte counts as signaling only when `byte_vld_i` is 1, `frame_i` (1-based within the multiframe) is a nonzero multiple of 6 no larger than the multiframe length, and `chan_i` is 0 to 23. Its signaling bit is `byte_i[0]`.
- R2: With `fmt_i`=0 (12-frame multiframe), frame 6 gives A and frame 12 gives B. The stored nibble is {A,B,A,B}, with bit 3=A, bit 2=B, bit 1=C and bit 0=D, whatever the value of `sixteen_i`.
- R3: With `fmt_i`=1 (24 frames) or `fmt_i`=2 (72 frames) and `sixteen_i`=0, let k=frame/6. Odd k gives A and even k gives B. The stored nibble is {A,B,A,B}, and the latest bit of each kind wins.
- R4: With `fmt_i`=1 or 2 and `sixteen_i`=1, the bit from k goes to A, B, C or D by (k-1) mod 4, and the latest bit wins.
- R5: A channel's codeword completes on its byte in the last frame of the multiframe. The store is written at the following clock edge.
- R6: With `deb_en_i`=1, a completed codeword is stored only if it equals the previous completed codeword of that channel.
- R7: A completed codeword is discarded when `freeze_i`, `sync_loss_i` or `slip_i` is 1 in its cycle. It is also discarded when `sync_loss_i` or `slip_i` was 1 earlier in the same multiframe; that hold is released after channel 23 of the last frame.
- R8: A stored value that differs from the old one sets that channel's change flag. `irq_o` = `sig_ie_i` AND (any flag set).
- R9: Address 0..23 read returns {3'b0, enable, nibble}, and a write sets the enable from `acc_wdata_i[4]`. Enables reset to 1 and stores reset to 0. A disabled channel's store is never written. `acc_rdata_o` is valid the cycle after the strobe.
- R10: A read at address 0x40+g returns flags 8g..8g+7 and clears them. A flag that is set in the same cycle as it is cleared stays set.
- R11: One cycle after each valid byte, `out_vld_o`=1, `data_o` equals that byte, and `sig_o` is {4'b0000, that channel's stored nibble as it was before that cycle's update}.
- R12: With `fmt_i`=3, no codeword is completed and the store and flags stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_i | input | 2 | 0: 12-frame, 1: 24-frame, 2: 72-frame, 3: no signaling |
| sixteen_i | input | 1 | 16-state selection |
| deb_en_i | input | 1 | Debounce enable |
| freeze_i | input | 1 | Software freeze |
| sync_loss_i | input | 1 | Frame sync lost |
| slip_i | input | 1 | Elastic buffer slip |
| sig_ie_i | input | 1 | Interrupt enable |
| byte_vld_i | input | 1 | Channel byte valid |
| byte_i | input | 8 | Channel byte |
| frame_i | input | 7 | Frame number in multiframe, 1-based |
| chan_i | input | 5 | Channel number 0..23 |
| acc_stb_i | input | 1 | Indirect access strobe |
| acc_rd_i | input | 1 | 1 = read, 0 = write |
| acc_addr_i | input | 7 | Indirect address |
| acc_wdata_i | input | 8 | Write data |
| acc_rdata_o | output | 8 | Read data |
| out_vld_o | output | 1 | Output slot valid |
| data_o | output | 8 | Delayed channel byte |
| sig_o | output | 8 | Signaling byte, codeword in low nibble |
| irq_o | output | 1 | Interrupt |

## Verification
The collision of concern is between a change flag being set by a codeword completion and the same flag group being cleared by a host read in the same cycle. The bench strobes a read of a flag group on the exact cycle in which a channel of that group completes its codeword. It then checks that the read returns the flags as they were before that cycle, and that the completing channel's flag survives the clear while its group-mates are cleared.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
    localparam int NUM_CH = 24;
    localparam int CH_W   = 5;
    localparam int FR_W   = 7;
    localparam int ADDR_W = 7;
    localparam logic [ADDR_W-1:0] COS_BASE = 7'h40;

    typedef enum logic [1:0] {
        FMT_MF12  = 2'd0,
        FMT_MF24  = 2'd1,
        FMT_MF72  = 2'd2,
        FMT_NOSIG = 2'd3
    } fmt_e;

    typedef struct packed {
        logic            vld;
        logic [CH_W-1:0] ch;
        logic [3:0]      cw;
    } cw_evt_t;

    function automatic logic [FR_W-1:0] mf_len(fmt_e f);
        case (f)
            FMT_MF12: return FR_W'(12);
            FMT_MF72: return FR_W'(72);
            default:  return FR_W'(24);
        endcase
    endfunction

    // slot 0..3 selects A..D
    function automatic logic [1:0] sig_slot(logic [FR_W-1:0] frame, logic wide);
        logic [FR_W-1:0] k;
        logic [FR_W-1:0] km1;
        k   = frame / FR_W'(6);
        km1 = k - FR_W'(1);
        return wide ? km1[1:0] : {1'b0, km1[0]};
    endfunction

    function automatic logic [3:0] finish_cw(logic [3:0] m, logic wide);
        return wide ? m : {m[3], m[2], m[3], m[2]};
    endfunction
endpackage

// File: rtl/rbs_assembler.sv
module rbs_assembler
    import rbs_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int CW  = CH_W,
    parameter int FW  = FR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  fmt_e          fmt_i,
    input  logic          sixteen_i,
    input  logic          vld_i,
    input  logic          bit_i,
    input  logic [FW-1:0] frame_i,
    input  logic [CW-1:0] ch_i,
    output cw_evt_t       evt_o
);
    logic [3:0] part [NCH];
    logic       wide;
    logic       is_sig;
    logic [3:0] mask;
    logic [3:0] merged;

    assign wide   = (fmt_i != FMT_MF12) && sixteen_i;
    assign is_sig = vld_i && (fmt_i != FMT_NOSIG) && (frame_i != '0)
                  && ((frame_i % FW'(6)) == '0) && (frame_i <= mf_len(fmt_i))
                  && (ch_i < CW'(NCH));
    assign mask   = 4'b1000 >> sig_slot(frame_i, wide);
    assign merged = (part[ch_i] & ~mask) | (bit_i ? mask : 4'b0000);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) part[i] <= '0;
        end else if (is_sig) begin
            part[ch_i] <= merged;
        end
    end

    assign evt_o.vld = is_sig && (frame_i == mf_len(fmt_i));
    assign evt_o.ch  = ch_i;
    assign evt_o.cw  = finish_cw(merged, wide);

    AST_NARROW_MIRROR: assert property (@(posedge clk) disable iff (rst)
        (evt_o.vld && !wide) |-> (evt_o.cw[1:0] == evt_o.cw[3:2]));  // R3
endmodule

// File: rtl/rbs_freeze_ctl.sv
module rbs_freeze_ctl (
    input  logic clk,
    input  logic rst,
    input  logic freeze_i,
    input  logic sync_loss_i,
    input  logic slip_i,
    input  logic mf_end_i,
    output logic frz_o
);
    logic hold;

    assign frz_o = freeze_i || sync_loss_i || slip_i || hold;

    always_ff @(posedge clk) begin
        if (rst)                        hold <= 1'b0;
        else if (mf_end_i)              hold <= 1'b0;
        else if (sync_loss_i || slip_i) hold <= 1'b1;
    end

    AST_HOLD_SPANS: assert property (@(posedge clk) disable iff (rst)
        ((sync_loss_i || slip_i) && !mf_end_i) |=> frz_o);  // R7
endmodule

// File: rtl/rbs_store.sv
module rbs_store
    import rbs_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int CW  = CH_W,
    parameter int AW  = ADDR_W
) (
    input  logic           clk,
    input  logic           rst,
    input  cw_evt_t        evt_i,
    input  logic           frz_i,
    input  logic           deb_en_i,
    input  logic           acc_stb_i,
    input  logic           acc_rd_i,
    input  logic [AW-1:0]  acc_addr_i,
    input  logic [7:0]     acc_wdata_i,
    input  logic [CW-1:0]  rd_ch_i,
    output logic [7:0]     rdata_o,
    output logic [NCH-1:0] cos_o,
    output logic [3:0]     cw_rd_o
);
    localparam int NGRP = (NCH + 7) / 8;
    localparam int PADW = NGRP * 8;
    localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1;

    logic [3:0]     store [NCH];
    logic [3:0]     last  [NCH];
    logic [NCH-1:0] ext;
    logic [NCH-1:0] cos;
    logic [NCH-1:0] cos_n;
    logic [NCH*4-1:0] store_flat;
    logic [PADW-1:0] cos_pad;
    logic [GW-1:0]  grp_idx;
    logic           ev_ok, accept, change, rd_stb;
    logic [7:0]     rd_mux;

    assign ev_ok  = evt_i.vld && ext[evt_i.ch];
    assign accept = ev_ok && !frz_i && (!deb_en_i || (evt_i.cw == last[evt_i.ch]));
    assign change = accept && (evt_i.cw != store[evt_i.ch]);
    assign rd_stb = acc_stb_i && acc_rd_i;
    assign cos_pad = PADW'(cos);
    assign grp_idx = GW'(acc_addr_i - COS_BASE);

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            logic set_c, clr_c;
            assign set_c    = change && (evt_i.ch == CW'(g));
            assign clr_c    = rd_stb && (acc_addr_i == COS_BASE + AW'(g / 8));
            assign cos_n[g] = set_c || (cos[g] && !clr_c);
            assign store_flat[g*4 +: 4] = store[g];

            AST_FLAG_WITH_CHANGE: assert property (@(posedge clk) disable iff (rst)
                $rose(cos[g]) |-> (store[g] != $past(store[g])));  // R8
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        if (acc_addr_i < AW'(NCH))
            rd_mux = {3'b000, ext[acc_addr_i[CW-1:0]], store[acc_addr_i[CW-1:0]]};
        else if (acc_addr_i >= COS_BASE && acc_addr_i < COS_BASE + AW'(NGRP))
            rd_mux = cos_pad[grp_idx*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) begin
                store[i] <= '0;
                last[i]  <= '0;
            end
            ext     <= '1;
            cos     <= '0;
            rdata_o <= '0;
        end else begin
            if (ev_ok)  last[evt_i.ch]  <= evt_i.cw;
            if (change) store[evt_i.ch] <= evt_i.cw;
            if (rd_stb) rdata_o <= rd_mux;
            if (acc_stb_i && !acc_rd_i && acc_addr_i < AW'(NCH))
                ext[acc_addr_i[CW-1:0]] <= acc_wdata_i[4];
            cos <= cos_n;
        end
    end

    assign cos_o   = cos;
    assign cw_rd_o = (rd_ch_i < CW'(NCH)) ? store[rd_ch_i] : 4'b0000;

    AST_FREEZE_STABLE: assert property (@(posedge clk) disable iff (rst)
        frz_i |=> $stable(store_flat));  // R7
    AST_DEBOUNCE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (evt_i.vld && deb_en_i && evt_i.cw != last[evt_i.ch]) |=> $stable(store_flat));  // R6
    AST_DISABLED_STABLE: assert property (@(posedge clk) disable iff (rst)
        (evt_i.vld && !ext[evt_i.ch]) |=> $stable(store_flat));  // R9
endmodule

// File: rtl/rbs_extractor.sv
module rbs_extractor
    import rbs_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int CW  = CH_W,
    parameter int FW  = FR_W,
    parameter int AW  = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    fmt_i,
    input  logic          sixteen_i,
    input  logic          deb_en_i,
    input  logic          freeze_i,
    input  logic          sync_loss_i,
    input  logic          slip_i,
    input  logic          sig_ie_i,
    input  logic          byte_vld_i,
    input  logic [7:0]    byte_i,
    input  logic [FW-1:0] frame_i,
    input  logic [CW-1:0] chan_i,
    input  logic          acc_stb_i,
    input  logic          acc_rd_i,
    input  logic [AW-1:0] acc_addr_i,
    input  logic [7:0]    acc_wdata_i,
    output logic [7:0]    acc_rdata_o,
    output logic          out_vld_o,
    output logic [7:0]    data_o,
    output logic [7:0]    sig_o,
    output logic          irq_o
);
    fmt_e           fmt;
    cw_evt_t        evt;
    logic           frz;
    logic           mf_end;
    logic [NCH-1:0] cos;
    logic [3:0]     cw_rd;

    assign fmt    = fmt_e'(fmt_i);
    assign mf_end = byte_vld_i && (frame_i == mf_len(fmt)) && (chan_i == CW'(NCH - 1));

    rbs_assembler #(.NCH(NCH), .CW(CW), .FW(FW)) u_asm (
        .clk(clk), .rst(rst), .fmt_i(fmt), .sixteen_i(sixteen_i),
        .vld_i(byte_vld_i), .bit_i(byte_i[0]), .frame_i(frame_i),
        .ch_i(chan_i), .evt_o(evt));

    rbs_freeze_ctl u_frz (
        .clk(clk), .rst(rst), .freeze_i(freeze_i), .sync_loss_i(sync_loss_i),
        .slip_i(slip_i), .mf_end_i(mf_end), .frz_o(frz));

    rbs_store #(.NCH(NCH), .CW(CW), .AW(AW)) u_store (
        .clk(clk), .rst(rst), .evt_i(evt), .frz_i(frz), .deb_en_i(deb_en_i),
        .acc_stb_i(acc_stb_i), .acc_rd_i(acc_rd_i), .acc_addr_i(acc_addr_i),
        .acc_wdata_i(acc_wdata_i), .rd_ch_i(chan_i), .rdata_o(acc_rdata_o),
        .cos_o(cos), .cw_rd_o(cw_rd));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld_o <= 1'b0;
            data_o    <= '0;
            sig_o     <= '0;
        end else begin
            out_vld_o <= byte_vld_i;
            if (byte_vld_i) begin
                data_o <= byte_i;
                sig_o  <= {4'b0000, cw_rd};
            end
        end
    end

    assign irq_o = sig_ie_i && (|cos);

    AST_SLOT_TRACKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        byte_vld_i |=> (out_vld_o && data_o == $past(byte_i)));  // R11
endmodule

// File: tb/rbs_extractor_test.sv
`timescale 1ns/1ps
module rbs_extractor_test;
    logic clk = 1'b0;
    logic rst;
    logic [1:0] fmt_i;
    logic sixteen_i, deb_en_i, freeze_i, sync_loss_i, slip_i, sig_ie_i;
    logic byte_vld_i;
    logic [7:0] byte_i;
    logic [6:0] frame_i;
    logic [4:0] chan_i;
    logic acc_stb_i, acc_rd_i;
    logic [6:0] acc_addr_i;
    logic [7:0] acc_wdata_i, acc_rdata_o, data_o, sig_o;
    logic out_vld_o, irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [3:0] exp_store [24];
    logic [3:0] exp_last  [24];
    logic       exp_ext   [24];
    logic       exp_cos   [24];
    bit         hold_m;

    always #2.5 clk = ~clk;

    rbs_extractor uut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic bitv(input int ch, input int k, input int seed);
        int v;
        v = ch * 29 + k * 17 + seed * 41;
        return v[3];
    endfunction

    function automatic logic [3:0] exp_cw(input int fmt, input bit wide, input int ch, input int seed);
        int k0;
        if (fmt == 0) return {bitv(ch,1,seed), bitv(ch,2,seed), bitv(ch,1,seed), bitv(ch,2,seed)};
        k0 = (fmt == 2) ? 8 : 0;
        if (wide) return {bitv(ch,k0+1,seed), bitv(ch,k0+2,seed), bitv(ch,k0+3,seed), bitv(ch,k0+4,seed)};
        return {bitv(ch,k0+3,seed), bitv(ch,k0+4,seed), bitv(ch,k0+3,seed), bitv(ch,k0+4,seed)};
    endfunction

    task automatic host_read(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk);
        acc_stb_i = 1'b1; acc_rd_i = 1'b1; acc_addr_i = a;
        @(negedge clk);
        d = acc_rdata_o;
        acc_stb_i = 1'b0;
    endtask

    task automatic host_write(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_stb_i = 1'b1; acc_rd_i = 1'b0; acc_addr_i = a; acc_wdata_i = d;
        @(negedge clk);
        acc_stb_i = 1'b0;
    endtask

    // one multiframe; -1 disables slip, sync-loss or concurrent read
    task automatic run_mf(input int fmt, input bit wide, input int seed,
                          input int slip_f, input int slip_ch,
                          input int sl_f, input int sl_ch, input int rd_ch);
        int len;
        len = (fmt == 0) ? 12 : ((fmt == 2) ? 72 : 24);
        fmt_i = 2'(fmt); sixteen_i = wide;
        for (int f = 1; f <= len; f++) begin
            for (int ch = 0; ch < 24; ch++) begin
                logic [7:0] d, rd_exp;
                logic [3:0] prev, cw;
                bit slx, sly, frz, rd_now;
                int base;
                base = ch * 37 + f * 11 + seed;
                d = base[7:0];
                if (f % 6 == 0) d[0] = bitv(ch, f / 6, seed);
                slx = (f == sl_f && ch == sl_ch);
                sly = (f == slip_f && ch == slip_ch);
                rd_now = (f == len && ch == rd_ch);
                byte_vld_i = 1'b1; byte_i = d; frame_i = 7'(f); chan_i = 5'(ch);
                sync_loss_i = slx; slip_i = sly;
                acc_stb_i = rd_now; acc_rd_i = 1'b1; acc_addr_i = 7'h40 + 7'(rd_ch / 8);
                prev = exp_store[ch];
                rd_exp = '0;
                if (rd_now) begin
                    for (int j = 0; j < 8; j++) begin
                        rd_exp[j] = exp_cos[(rd_ch / 8) * 8 + j];
                        exp_cos[(rd_ch / 8) * 8 + j] = 1'b0;
                    end
                end
                frz = freeze_i || slx || sly || hold_m;
                if (f == len && fmt != 3 && exp_ext[ch]) begin
                    cw = exp_cw(fmt, wide, ch, seed);
                    if (!frz && (!deb_en_i || cw == exp_last[ch]) && cw != exp_store[ch]) begin
                        exp_store[ch] = cw;
                        exp_cos[ch] = 1'b1;
                    end
                    exp_last[ch] = cw;
                end
                if (f == len && ch == 23) hold_m = 1'b0;
                else if (slx || sly) hold_m = 1'b1;
                @(negedge clk);
                chk(out_vld_o && data_o == d && sig_o == {4'b0000, prev},
                    "R11 slot", {out_vld_o, data_o, sig_o}, {1'b1, d, 4'b0000, prev});
                if (rd_now) begin
                    chk(acc_rdata_o == rd_exp, "R10 concurrent read value", acc_rdata_o, rd_exp);
                end
                acc_stb_i = 1'b0; sync_loss_i = 1'b0; slip_i = 1'b0;
            end
        end
        byte_vld_i = 1'b0;
    endtask

    task automatic check_all(input string tag);
        logic [7:0] d, e;
        bit any;
        any = 1'b0;
        for (int c = 0; c < 24; c++) any |= exp_cos[c];
        chk(irq_o == (sig_ie_i && any), {tag, " R8 irq"}, irq_o, sig_ie_i && any);
        for (int c = 0; c < 24; c++) begin
            host_read(7'(c), d);
            e = {3'b000, exp_ext[c], exp_store[c]};
            chk(d == e, {tag, " R9 store read"}, d, e);
        end
        for (int g = 0; g < 3; g++) begin
            host_read(7'h40 + 7'(g), d);
            for (int j = 0; j < 8; j++) begin
                e[j] = exp_cos[g * 8 + j];
                exp_cos[g * 8 + j] = 1'b0;
            end
            chk(d == e, {tag, " R8 R10 flag group"}, d, e);
        end
        @(negedge clk);
        chk(irq_o == 1'b0, {tag, " R10 flags cleared by read"}, irq_o, 0);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(5ns * 190000);
        n_tests++; n_fail++;
        $display("FAIL watchdog R5 actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        rst = 1'b1;
        fmt_i = 0; sixteen_i = 0; deb_en_i = 0; freeze_i = 0; sync_loss_i = 0;
        slip_i = 0; sig_ie_i = 1; byte_vld_i = 0; byte_i = 0; frame_i = 0; chan_i = 0;
        acc_stb_i = 0; acc_rd_i = 1; acc_addr_i = 0; acc_wdata_i = 0; hold_m = 0;
        for (int c = 0; c < 24; c++) begin
            exp_store[c] = 0; exp_last[c] = 0; exp_ext[c] = 1; exp_cos[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(out_vld_o == 0 && irq_o == 0, "R9 reset outputs", {out_vld_o, irq_o}, 0);
        host_read(7'd0, d);
        chk(d == 8'h10, "R9 reset enable and store", d, 8'h10);

        run_mf(0, 0, 1, -1, -1, -1, -1, -1); check_all("R1 R2 12-frame");
        run_mf(0, 1, 6, -1, -1, -1, -1, -1); check_all("R2 12-frame wide ignored");
        run_mf(1, 0, 2, -1, -1, -1, -1, -1); check_all("R3 24-frame 4-state");
        run_mf(1, 1, 3, -1, -1, -1, -1, -1); check_all("R4 24-frame 16-state");
        run_mf(2, 0, 4, -1, -1, -1, -1, -1); check_all("R3 72-frame 4-state");
        run_mf(2, 1, 5, -1, -1, -1, -1, -1); check_all("R4 R5 72-frame 16-state");

        sig_ie_i = 0;
        run_mf(1, 1, 14, -1, -1, -1, -1, -1); check_all("R8 irq masked");
        sig_ie_i = 1;

        deb_en_i = 1;
        run_mf(1, 1, 7, -1, -1, -1, -1, -1); check_all("R6 first codeword");
        run_mf(1, 1, 7, -1, -1, -1, -1, -1); check_all("R6 repeated codeword");
        deb_en_i = 0;

        freeze_i = 1;
        run_mf(1, 0, 8, -1, -1, -1, -1, -1); check_all("R7 software freeze");
        freeze_i = 0;
        run_mf(1, 1, 9, -1, -1, 3, 0, -1);   check_all("R7 sync loss held");
        run_mf(1, 0, 10, 24, 5, -1, -1, -1); check_all("R7 slip at completion");
        run_mf(1, 0, 10, -1, -1, -1, -1, -1); check_all("R7 hold released");

        host_write(7'd3, 8'h00); exp_ext[3] = 0;
        host_write(7'd20, 8'h00); exp_ext[20] = 0;
        run_mf(2, 1, 11, -1, -1, -1, -1, -1); check_all("R9 extract disabled");
        host_write(7'd3, 8'h10); exp_ext[3] = 1;
        host_write(7'd20, 8'h10); exp_ext[20] = 1;

        run_mf(3, 1, 12, -1, -1, -1, -1, -1); check_all("R12 no signaling");

        run_mf(1, 1, 13, -1, -1, -1, -1, 2); check_all("R10 set beats clear");
        run_mf(0, 0, 15, -1, -1, -1, -1, 21); check_all("R10 set beats clear high group");

        finish_run();
    end
endmodule